// File: doc/BRIEF.md
# Snoop Response Combiner

This block collects the snoop replies that a set of caches return for one bus transaction and turns them into a single collective answer. Each cache reports whether it holds a copy of the addressed block (shared), whether its copy is modified (dirty), and when its lookup is done (ready). The combiner merges these into wired-OR style shared and dirty results and qualifies them with a snoop-valid signal. Memory and the requesting cache sample the results only while snoop-valid is high.

From the merged result the block decides whether memory supplies the block or must stay quiet while the owning cache supplies it. It also tells the requester whether to install the line as exclusive or shared. There are two completion modes. In the variable-latency mode, snoop-valid waits until every cache has answered, so memory may fetch speculatively and still deliver only once no cache has claimed ownership. In the fixed-latency mode, snoop-valid rises a programmed number of cycles after the address strobe, and an error flag marks a transaction in which some cache had not answered by then.

Top module: `snoop_combiner`

## Requirements
- R1: While reset is held, every output is low.
- R2: Once snoop-valid is high, shared_o is the OR of the shared bits captured from the caches counted in the transaction, and dirty_o is the OR of their dirty bits.
- R3: Before snoop-valid rises in a transaction, shared_o, dirty_o, mem_supply_o, mem_inhibit_o, fill_excl_o and timeout_err_o are all low.
- R4: With mode_fixed_i = 0 sampled at the strobe, snoop-valid is high from the clock edge at which the last outstanding cache's ready is captured. Ready inputs in the strobe cycle itself are ignored.
- R5: While snoop-valid is high, mem_supply_o = 1 exactly when dirty_o = 0, and mem_inhibit_o = 1 exactly when dirty_o = 1.
- R6: While snoop-valid is high, fill_excl_o = 1 (install exclusive) when shared_o = 0, and fill_excl_o = 0 (install shared) when shared_o = 1.
- R7: With mode_fixed_i = 1 sampled at the strobe, snoop-valid rises exactly K clock edges after the strobe edge, where K = fixed_lat_i and a K of 0 acts as 1. Caches not ready by then add nothing to shared_o or dirty_o, and timeout_err_o is high together with snoop-valid when any cache was not ready.
- R8: A cache's reply is captured in the first cycle after the strobe in which its ready is high. Later ready pulses and changes on its shared or dirty inputs, including any after snoop-valid, leave the result unchanged.
- R9: An address strobe starts a new transaction. At the next edge it clears snoop-valid, the error flag and all captured replies, and it samples mode_fixed_i and fixed_lat_i. Those two inputs are ignored in all other cycles.
- R10: After snoop-valid rises, all outputs hold their values until the next address strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_strobe_i | input | 1 | Address phase of a new transaction |
| mode_fixed_i | input | 1 | 1 = fixed-latency completion, 0 = wait for all caches; sampled at the strobe |
| fixed_lat_i | input | CNT_W | Snoop window K in cycles for the fixed mode; sampled at the strobe |
| snp_shared_i | input | N_CACHES | Per-cache copy-present reply |
| snp_dirty_i | input | N_CACHES | Per-cache modified-copy reply |
| snp_ready_i | input | N_CACHES | Per-cache lookup-complete indication |
| shared_o | output | 1 | Combined shared result |
| dirty_o | output | 1 | Combined dirty result |
| snoop_valid_o | output | 1 | Results may be sampled |
| mem_supply_o | output | 1 | Memory delivers the block |
| mem_inhibit_o | output | 1 | Memory stays quiet; the owning cache supplies the block |
| fill_excl_o | output | 1 | Requester fill state: 1 exclusive, 0 shared |
| timeout_err_o | output | 1 | Fixed mode: some cache missed the window |

## Verification
The assertions assume that an address strobe comes before any transaction's replies matter, and that in the variable mode every cache eventually raises ready. Without that, snoop-valid never rises, and the hold and exclusivity properties become vacuous. The stimulus keeps to these assumptions. Each transaction opens with a one-cycle strobe. In the variable mode every cache gets a ready cycle between 1 and 8 cycles after the strobe. Random values on ready, shared, dirty, mode and window are driven only in cycles where the requirements say they must be ignored: the strobe cycle, after a cache's own capture, and non-strobe cycles for the mode and window inputs.

// File: rtl/snoop_cmb_pkg.sv
package snoop_cmb_pkg;
  typedef enum logic {
    LAT_VARIABLE = 1'b0,
    LAT_FIXED    = 1'b1
  } lat_mode_e;
endpackage

// File: rtl/snoop_reply_latch.sv
module snoop_reply_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic capture_i,
  input  logic ready_i,
  input  logic shared_i,
  input  logic dirty_i,
  output logic rdy_o,
  output logic rdy_nxt_o,
  output logic shared_o,
  output logic dirty_o
);
  logic rdy_q, sh_q, dt_q, take;

  assign take      = capture_i & ready_i & ~rdy_q;
  assign rdy_nxt_o = rdy_q | (capture_i & ready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q <= 1'b0;
      sh_q  <= 1'b0;
      dt_q  <= 1'b0;
    end else if (clear_i) begin
      rdy_q <= 1'b0;
      sh_q  <= 1'b0;
      dt_q  <= 1'b0;
    end else if (take) begin
      rdy_q <= 1'b1;
      sh_q  <= shared_i;
      dt_q  <= dirty_i;
    end
  end

  assign rdy_o    = rdy_q;
  assign shared_o = sh_q;
  assign dirty_o  = dt_q;

  // R8: first reply sticks until the next strobe
  a_r8_reply_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_q && !clear_i |=> rdy_q && $stable(sh_q) && $stable(dt_q));
  a_r8_unready_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_q |-> !sh_q && !dt_q);
endmodule

// File: rtl/snoop_window_timer.sv
module snoop_window_timer
  import snoop_cmb_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic             mode_fixed_i,
  input  logic [CNT_W-1:0] lat_i,
  input  logic             all_rdy_nxt_i,
  output logic             capture_o,
  output logic             valid_o,
  output logic             err_o,
  output lat_mode_e        mode_o
);
  localparam int CMP_W = CNT_W + 1;

  logic             busy_q, valid_q, err_q;
  logic [CNT_W-1:0] cnt_q, lat_q;
  lat_mode_e        mode_q;
  logic [CMP_W-1:0] cnt_inc;
  logic             win_done;

  assign cnt_inc  = {1'b0, cnt_q} + CMP_W'(1);
  assign win_done = cnt_inc >= {1'b0, lat_q};   // lat 0 behaves as 1

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      cnt_q   <= '0;
      lat_q   <= '0;
      mode_q  <= LAT_VARIABLE;
    end else if (strobe_i) begin
      busy_q  <= 1'b1;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      cnt_q   <= '0;
      lat_q   <= lat_i;
      mode_q  <= lat_mode_e'(mode_fixed_i);
    end else if (busy_q && !valid_q) begin
      cnt_q <= cnt_inc[CNT_W-1:0];
      if (mode_q == LAT_FIXED) begin
        if (win_done) begin
          valid_q <= 1'b1;
          err_q   <= ~all_rdy_nxt_i;
        end
      end else if (all_rdy_nxt_i) begin
        valid_q <= 1'b1;
      end
    end
  end

  assign capture_o = busy_q & ~valid_q;
  assign valid_o   = valid_q;
  assign err_o     = err_q;
  assign mode_o    = mode_q;

  a_r7_err_fixed_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> valid_q && mode_q == LAT_FIXED);
  a_r10_valid_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && !strobe_i |=> valid_q && $stable(err_q));
  a_r9_strobe_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> !valid_q && !err_q);
  a_r3_valid_needs_txn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> busy_q);
endmodule

// File: rtl/snoop_resolve.sv
module snoop_resolve #(
  parameter int N_CACHES = 4
) (
  input  logic                valid_i,
  input  logic                err_i,
  input  logic [N_CACHES-1:0] sh_i,
  input  logic [N_CACHES-1:0] dt_i,
  output logic                shared_o,
  output logic                dirty_o,
  output logic                mem_supply_o,
  output logic                mem_inhibit_o,
  output logic                fill_excl_o,
  output logic                err_o
);
  logic any_sh, any_dt;

  assign any_sh = |sh_i;
  assign any_dt = |dt_i;

  // everything gated by valid: results are inhibited until snoop completes
  always_comb begin
    shared_o      = valid_i & any_sh;
    dirty_o       = valid_i & any_dt;
    mem_supply_o  = valid_i & ~any_dt;
    mem_inhibit_o = valid_i & any_dt;
    fill_excl_o   = valid_i & ~any_sh;
    err_o         = valid_i & err_i;
  end
endmodule

// File: rtl/snoop_combiner.sv
module snoop_combiner
  import snoop_cmb_pkg::*;
#(
  parameter int N_CACHES = 4,
  parameter int CNT_W    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                addr_strobe_i,
  input  logic                mode_fixed_i,
  input  logic [CNT_W-1:0]    fixed_lat_i,
  input  logic [N_CACHES-1:0] snp_shared_i,
  input  logic [N_CACHES-1:0] snp_dirty_i,
  input  logic [N_CACHES-1:0] snp_ready_i,
  output logic                shared_o,
  output logic                dirty_o,
  output logic                snoop_valid_o,
  output logic                mem_supply_o,
  output logic                mem_inhibit_o,
  output logic                fill_excl_o,
  output logic                timeout_err_o
);
  logic [N_CACHES-1:0] rdy_q, rdy_nxt, sh_q, dt_q;
  logic                capture, valid, err;
  lat_mode_e           mode_q;

  for (genvar g = 0; g < N_CACHES; g++) begin : g_port
    snoop_reply_latch u_latch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clear_i   (addr_strobe_i),
      .capture_i (capture),
      .ready_i   (snp_ready_i[g]),
      .shared_i  (snp_shared_i[g]),
      .dirty_i   (snp_dirty_i[g]),
      .rdy_o     (rdy_q[g]),
      .rdy_nxt_o (rdy_nxt[g]),
      .shared_o  (sh_q[g]),
      .dirty_o   (dt_q[g])
    );
  end

  snoop_window_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .strobe_i      (addr_strobe_i),
    .mode_fixed_i  (mode_fixed_i),
    .lat_i         (fixed_lat_i),
    .all_rdy_nxt_i (&rdy_nxt),
    .capture_o     (capture),
    .valid_o       (valid),
    .err_o         (err),
    .mode_o        (mode_q)
  );

  snoop_resolve #(.N_CACHES(N_CACHES)) u_resolve (
    .valid_i       (valid),
    .err_i         (err),
    .sh_i          (sh_q),
    .dt_i          (dt_q),
    .shared_o      (shared_o),
    .dirty_o       (dirty_o),
    .mem_supply_o  (mem_supply_o),
    .mem_inhibit_o (mem_inhibit_o),
    .fill_excl_o   (fill_excl_o),
    .err_o         (timeout_err_o)
  );

  assign snoop_valid_o = valid;

  a_r5_mem_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_valid_o |-> $onehot({mem_supply_o, mem_inhibit_o}));
  a_r3_quiet_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snoop_valid_o |-> !(shared_o | dirty_o | mem_supply_o | mem_inhibit_o
                         | fill_excl_o | timeout_err_o));
  a_r4_all_answered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(snoop_valid_o) && mode_q == LAT_VARIABLE |-> &rdy_q);
  a_r7_err_means_missing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_err_o |-> !(&rdy_q));
  a_r6_fill_vs_shared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_valid_o |-> fill_excl_o != shared_o);
endmodule

// File: tb/sim_snoop_combiner.sv
module sim_snoop_combiner;
  localparam int N  = 4;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          addr_strobe_i = 1'b0;
  logic          mode_fixed_i = 1'b0;
  logic [CW-1:0] fixed_lat_i = '0;
  logic [N-1:0]  snp_shared_i = '0, snp_dirty_i = '0, snp_ready_i = '0;
  logic shared_o, dirty_o, snoop_valid_o, mem_supply_o, mem_inhibit_o;
  logic fill_excl_o, timeout_err_o;

  always #4 clk = ~clk;  // 125 MHz

  snoop_combiner #(.N_CACHES(N), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_strobe_i(addr_strobe_i),
    .mode_fixed_i(mode_fixed_i), .fixed_lat_i(fixed_lat_i),
    .snp_shared_i(snp_shared_i), .snp_dirty_i(snp_dirty_i), .snp_ready_i(snp_ready_i),
    .shared_o(shared_o), .dirty_o(dirty_o), .snoop_valid_o(snoop_valid_o),
    .mem_supply_o(mem_supply_o), .mem_inhibit_o(mem_inhibit_o),
    .fill_excl_o(fill_excl_o), .timeout_err_o(timeout_err_o)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  int dly[N];
  bit rsh[N], rdt[N];

  function automatic logic [6:0] outs();
    return {snoop_valid_o, shared_o, dirty_o, mem_supply_o, mem_inhibit_o,
            fill_excl_o, timeout_err_o};
  endfunction

  function automatic logic [6:0] expect_vec(bit v, bit sh, bit dt, bit er);
    return v ? {1'b1, sh, dt, ~dt, dt, ~sh, er} : 7'b0;
  endfunction

  task automatic chk(string tag, logic [6:0] act, logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic run_txn(bit fixed, int k);
    int keff, maxd, endc;
    bit sh, dt, er;
    keff = (k == 0) ? 1 : k;
    maxd = 1;
    for (int i = 0; i < N; i++) if (dly[i] > maxd) maxd = dly[i];
    endc = fixed ? keff : maxd;
    sh = 0; dt = 0; er = 0;
    for (int i = 0; i < N; i++) begin
      if (!fixed || dly[i] <= keff) begin
        sh |= rsh[i];
        dt |= rdt[i];
      end else er = 1;
    end
    for (int cyc = 0; cyc <= endc + 3; cyc++) begin
      addr_strobe_i = (cyc == 0);
      mode_fixed_i  = (cyc == 0) ? fixed : 1'($urandom % 2);
      fixed_lat_i   = (cyc == 0) ? CW'(k) : CW'($urandom);
      for (int i = 0; i < N; i++) begin
        if (cyc == dly[i]) begin
          snp_ready_i[i]  = 1'b1;
          snp_shared_i[i] = rsh[i];
          snp_dirty_i[i]  = rdt[i];
        end else begin
          // R8/R4: ready in the strobe cycle or after capture is noise
          snp_ready_i[i]  = (cyc == 0 || cyc > dly[i]) ? 1'($urandom % 2) : 1'b0;
          snp_shared_i[i] = 1'($urandom % 2);
          snp_dirty_i[i]  = 1'($urandom % 2);
        end
      end
      @(negedge clk);
      begin
        logic [6:0] e;
        string tag;
        e = expect_vec(cyc >= endc, sh, dt, er);
        if (cyc == 0)        tag = "R9 strobe clears";
        else if (cyc < endc) tag = "R3 inhibited before valid";
        else if (cyc == endc) tag = fixed ? "R7 fixed window" : "R4 all caches answered";
        else                 tag = "R10 hold until strobe";
        chk(tag, outs(), e);
        if (cyc == endc) begin
          chk("R2 shared/dirty OR", {5'b0, shared_o, dirty_o}, {5'b0, sh, dt});
          chk("R5 memory decision", {5'b0, mem_supply_o, mem_inhibit_o}, {5'b0, ~dt, dt});
          chk("R6 fill state", {6'b0, fill_excl_o}, {6'b0, ~sh});
        end
        if (cyc == endc + 3)
          chk("R8 later replies ignored", {5'b0, shared_o, dirty_o}, {5'b0, sh, dt});
      end
    end
  endtask

  task automatic set_caches(int d0, int d1, int d2, int d3,
                            bit [3:0] sh, bit [3:0] dt);
    dly[0] = d0; dly[1] = d1; dly[2] = d2; dly[3] = d3;
    for (int i = 0; i < N; i++) begin
      rsh[i] = sh[i];
      rdt[i] = dt[i];
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R1 reset outputs low", outs(), 7'b0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", outs(), 7'b0);

    set_caches(1, 2, 3, 2, 4'b0000, 4'b0000); run_txn(0, 0);  // exclusive, memory supplies
    set_caches(2, 7, 1, 3, 4'b0110, 4'b0010); run_txn(0, 5);  // late owner
    set_caches(1, 3, 2, 3, 4'b1000, 4'b0000); run_txn(1, 3);  // fixed, all in time
    set_caches(1, 5, 2, 6, 4'b1010, 4'b0010); run_txn(1, 2);  // fixed, misses excluded, error
    set_caches(1, 1, 1, 1, 4'b0001, 4'b0000); run_txn(1, 0);  // window 0 acts as 1
    set_caches(1, 2, 8, 1, 4'b0100, 4'b0100); run_txn(0, 1);  // back to back variable

    for (int t = 0; t < 60; t++) begin
      for (int i = 0; i < N; i++) begin
        dly[i] = 1 + int'($urandom % 8);
        rsh[i] = 1'($urandom % 2);
        rdt[i] = 1'($urandom % 4 == 0);
      end
      run_txn(1'($urandom % 2), int'($urandom % 7));
    end

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule